// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier with Signed Mode

This block multiplies two W-bit operands over several clock cycles. It uses one adder that is as wide as the product and no multiplier array. A request is issued by pulsing `start` while the block is idle. The operands and a per-request mode flag are captured on that edge. The flag selects whether the operands are read as unsigned integers or as two's-complement integers.

Internally the block always runs an unsigned shift-add loop. The loop has one step per multiplier bit. On each step, the lowest remaining multiplier bit decides whether the left-shifted multiplicand is added to a running sum or whether the step only shifts. In signed mode each negative operand is first replaced by its magnitude. The unsigned result is then negated in one extra cycle when the operand signs differ. The full 2W-bit product is registered and `done` pulses once.

Top module: `shiftadd_mult`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `busy` and `done` are 0 and `product` is 0.
- R2: A `start` sampled high while `busy` is low is accepted. `busy` is high from the next cycle on. `done` is high for exactly one cycle, W+1 clock edges after the accepting edge, and `busy` falls on that same edge.
- R3: With `is_signed` = 0, `product` equals the unsigned product of `op_a` and `op_b` in 2W bits (for W=8: 105 × 90 gives 0x24EA, and 0xFF × 0xFF gives 0xFE01).
- R4: With `is_signed` = 1, `product` is the 2W-bit two's-complement product of the operands. The same bits give a different result than in unsigned mode: for W=8, 0xD9 × 0x03 gives 0xFF8B (−117) signed and 0x028B (651) unsigned.
- R5: The most negative operand is handled exactly in signed mode. For W=8, 0x80 × 0x80 gives 0x4000 and 0x80 × 0x7F gives 0xC080.
- R6: A `start` sampled while `busy` is high is ignored. Neither the result nor the `done` timing of the running operation changes.
- R7: `product` changes only on the edge that raises `done`. It holds its value through idle cycles and through a following operation until that operation's `done`.
- R8: In signed mode the product of two negative operands is positive, and any product with a zero operand is 0 (for W=8: 0xF6 × 0xF6 gives 0x0064, and 0xFB × 0x00 gives 0x0000).
- R9: `op_a`, `op_b` and `is_signed` are sampled only on the accepting edge. Changing them while `busy` is high has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a multiply (accepted only when idle) |
| is_signed | input | 1 | 1: two's-complement operands, 0: unsigned |
| op_a | input | W | Multiplicand |
| op_b | input | W | Multiplier |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when `product` is updated |
| product | output | 2W | Registered 2W-bit product |

## Verification
A step counter that is off by one or a late final step appears within one operation. `done` moves away from the W+1 edge mark, and the top bits of `product` are wrong whenever the multiplier's top bit is set. A stale sign flag or a mishandled most-negative magnitude shows up as a wrong sign or a wrong magnitude on the next `done`. The mixed-sign and 0x80 cases expose these faults directly. A restart taken while busy appears as a late `done` or a result built from the wrong operands.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } mul_state_t;
endpackage

// File: rtl/mul_sign_prep.sv
// Converts operands to unsigned magnitudes and decides whether the
// unsigned result needs a final negation.
module mul_sign_prep #(
  parameter int W = 8
) (
  input  logic         is_signed,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_mag,
  output logic [W-1:0] b_mag,
  output logic         flip
);
  localparam int XW = W + 1;

  logic a_neg, b_neg;
  logic [XW-1:0] a_wide, b_wide, a_negw, b_negw;

  assign a_neg = is_signed & a_in[W-1];
  assign b_neg = is_signed & b_in[W-1];

  // widen by one sign bit so the most negative value negates to 2^(W-1)
  assign a_wide = {a_in[W-1], a_in};
  assign b_wide = {b_in[W-1], b_in};
  assign a_negw = ~a_wide + XW'(1);
  assign b_negw = ~b_wide + XW'(1);

  assign a_mag = a_neg ? a_negw[W-1:0] : a_in;
  assign b_mag = b_neg ? b_negw[W-1:0] : b_in;
  assign flip  = a_neg ^ b_neg;
endmodule

// File: rtl/mul_shift_core.sv
// Unsigned shift-add engine: one multiplier bit per step.
module mul_shift_core #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   mcand_in,
  input  logic [W-1:0]   mplier_in,
  output logic [2*W-1:0] sum,
  output logic           last_step
);
  localparam int PW = 2 * W;
  localparam int CW = $clog2(W + 1);

  logic [PW-1:0] acc_q, mc_q;
  logic [W-1:0]  mp_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      mc_q  <= '0;
      mp_q  <= '0;
      cnt_q <= '0;
    end else if (load) begin
      acc_q <= '0;
      mc_q  <= {{W{1'b0}}, mcand_in};
      mp_q  <= mplier_in;
      cnt_q <= '0;
    end else if (step) begin
      if (mp_q[0]) begin
        acc_q <= acc_q + mc_q;
      end
      mc_q  <= mc_q << 1;
      mp_q  <= mp_q >> 1;
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign sum       = acc_q;
  assign last_step = (cnt_q == CW'(W - 1));
endmodule

// File: rtl/mul_sign_fix.sv
// Conditional two's-complement of the unsigned result.
module mul_sign_fix #(
  parameter int W = 8
) (
  input  logic [2*W-1:0] raw,
  input  logic           flip,
  output logic [2*W-1:0] fixed
);
  localparam int PW = 2 * W;
  assign fixed = flip ? (~raw + PW'(1)) : raw;
endmodule

// File: rtl/shiftadd_mult.sv
module shiftadd_mult #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           is_signed,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);
  import mul_pkg::*;
  localparam int PW = 2 * W;

  mul_state_t    state_q;
  logic          busy_q, done_q, flip_q;
  logic [PW-1:0] prod_q;

  logic [W-1:0]  a_mag, b_mag;
  logic          flip_d, accept, load, step, last_step;
  logic [PW-1:0] raw_sum, fixed_sum;

  assign accept = start & (state_q == ST_IDLE);
  assign load   = accept;
  assign step   = (state_q == ST_RUN);

  mul_sign_prep #(.W(W)) u_prep (
    .is_signed (is_signed),
    .a_in      (op_a),
    .b_in      (op_b),
    .a_mag     (a_mag),
    .b_mag     (b_mag),
    .flip      (flip_d)
  );

  mul_shift_core #(.W(W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .step      (step),
    .mcand_in  (a_mag),
    .mplier_in (b_mag),
    .sum       (raw_sum),
    .last_step (last_step)
  );

  mul_sign_fix #(.W(W)) u_fix (
    .raw   (raw_sum),
    .flip  (flip_q),
    .fixed (fixed_sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      flip_q  <= 1'b0;
      prod_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= ST_RUN;
            busy_q  <= 1'b1;
            flip_q  <= flip_d;
          end
        end
        ST_RUN: begin
          if (last_step) begin
            state_q <= ST_FIX;
          end
        end
        ST_FIX: begin
          prod_q  <= fixed_sum;
          done_q  <= 1'b1;
          busy_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign product = prod_q;
endmodule

// File: rtl/shiftadd_mult_chk.sv
module shiftadd_mult_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic           is_signed,
  input logic [W-1:0]   op_a,
  input logic [W-1:0]   op_b,
  input logic           busy,
  input logic           done,
  input logic [2*W-1:0] product
);
  localparam int PW = 2 * W;
  localparam int TW = $clog2(W + 3);

  logic [TW-1:0] span_q;
  logic [PW-1:0] ref_q;
  logic signed [PW-1:0] sa, sb;

  assign sa = is_signed ? {{W{op_a[W-1]}}, op_a} : {{W{1'b0}}, op_a};
  assign sb = is_signed ? {{W{op_b[W-1]}}, op_b} : {{W{1'b0}}, op_b};

  always_ff @(posedge clk) begin
    if (rst) begin
      span_q <= '0;
      ref_q  <= '0;
    end else if (start && !busy) begin
      span_q <= '0;
      ref_q  <= PW'(sa * sb);
    end else if (busy) begin
      span_q <= span_q + TW'(1);
    end
  end

  // R1: outputs idle on the first cycle after reset
  assert_reset_idle_R1: assert property (@(posedge clk)
    $fell(rst) |-> (!busy && !done && product == '0));

  // R2: done is a single-cycle pulse
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2: done falls exactly W+1 edges after acceptance, busy already low
  assert_done_latency_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> (span_q == TW'(W + 1) && !busy && $past(busy)));

  // R3 R4 R5 R8 R9: result matches operands captured at acceptance
  assert_product_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> product == ref_q);

  // R7: product only moves together with done
  assert_product_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(product));

  // R6: a start while busy does not drop busy early
  assert_busy_kept_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && start && span_q < TW'(W)) |=> busy);
endmodule

bind shiftadd_mult shiftadd_mult_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .is_signed (is_signed),
  .op_a      (op_a),
  .op_b      (op_b),
  .busy      (busy),
  .done      (done),
  .product   (product)
);

// File: tb/sim_shiftadd_mult.sv
`timescale 1ns/1ps
module sim_shiftadd_mult;
  localparam int W  = 8;
  localparam int PW = 2 * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          is_signed = 1'b0;
  logic [W-1:0]  op_a = '0;
  logic [W-1:0]  op_b = '0;
  logic          busy, done;
  logic [PW-1:0] product;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  logic [PW-1:0] exp_q[$];
  string         tag_q[$];
  int            t0_q[$];

  shiftadd_mult #(.W(W)) u0 (
    .clk(clk), .rst(rst), .start(start), .is_signed(is_signed),
    .op_a(op_a), .op_b(op_b), .busy(busy), .done(done), .product(product)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [PW-1:0] model(input logic [W-1:0] a,
                                          input logic [W-1:0] b,
                                          input logic s);
    logic signed [PW-1:0] xa, xb;
    xa = s ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
    xb = s ? {{W{b[W-1]}}, b} : {{W{1'b0}}, b};
    return PW'(xa * xb);
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [PW-1:0] act, input logic [PW-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  // driver: issue one request and push its expected item
  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic s, input string tag, input bit disturb);
    while (busy) @(negedge clk);
    op_a = a; op_b = b; is_signed = s; start = 1'b1;
    @(negedge clk);
    exp_q.push_back(model(a, b, s));
    tag_q.push_back(tag);
    t0_q.push_back(cyc);
    start = 1'b0;
    if (disturb) begin
      // R6 R9: new request and flipped mode while busy must be ignored
      op_a = ~a; op_b = b + 8'd3; is_signed = ~s; start = 1'b1;
      @(negedge clk);
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  // monitor: pop and compare on each done
  always @(negedge clk) begin
    if (!rst && done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6", product, '0);
      end else begin
        logic [PW-1:0] e;
        string t;
        int t0;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        t0 = t0_q.pop_front();
        check(product == e, t, product, e);
        check(cyc == t0 + W + 1, "R2", PW'(cyc - t0), PW'(W + 1));
        check(!busy, "R2", PW'(busy), '0);
      end
    end
  end

  task automatic drain();
    while (exp_q.size() != 0 || busy) @(negedge clk);
  endtask

  initial begin
    logic [PW-1:0] held;
    repeat (3) @(negedge clk);
    check(!busy && !done && product == '0, "R1", product, '0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && product == '0, "R1", {busy, done, product[PW-3:0]}, '0);

    issue(8'd105, 8'd90,  1'b0, "R3", 1'b0);
    drain();
    check(product == 16'h24EA, "R3", product, 16'h24EA);
    issue(8'hFF, 8'hFF, 1'b0, "R3", 1'b0);
    issue(8'hD9, 8'h03, 1'b0, "R4", 1'b0);
    issue(8'hD9, 8'h03, 1'b1, "R4", 1'b0);
    drain();
    check(product == 16'hFF8B, "R4", product, 16'hFF8B);
    issue(8'hFF, 8'hFF, 1'b1, "R4", 1'b0);
    issue(8'h80, 8'h80, 1'b1, "R5", 1'b0);
    issue(8'h80, 8'h7F, 1'b1, "R5", 1'b0);
    drain();
    check(product == 16'hC080, "R5", product, 16'hC080);
    issue(8'hF6, 8'hF6, 1'b1, "R8", 1'b0);
    issue(8'hFB, 8'h00, 1'b1, "R8", 1'b0);
    issue(8'h13, 8'hC4, 1'b1, "R4", 1'b0);
    issue(8'h6B, 8'hA7, 1'b1, "R6", 1'b1);
    issue(8'h91, 8'h2E, 1'b0, "R9", 1'b1);
    drain();

    // R7: product holds through idle and through the next operation
    held = product;
    repeat (5) @(negedge clk);
    check(product == held, "R7", product, held);
    issue(8'h22, 8'h33, 1'b0, "R3", 1'b0);
    repeat (3) @(negedge clk);
    check(product == held, "R7", product, held);
    drain();
    check(product == 16'h06C6, "R7", product, 16'h06C6);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule